// File: doc/BRIEF.md
# Eight-Entry Page Translation Buffer

This block turns a 32-bit virtual address into a 15-bit physical address. It does so with a small fully associative table of eight mappings. Each mapping pairs a 20-bit virtual page number with a 20-bit physical page number. Pages are 4 KiB, so the low 12 address bits are the page offset and pass through unchanged. The physical address is the low three bits of the matched physical page number followed by that offset, which covers eight physical pages.

Slots 0 and 1 hold fixed mappings that nothing can alter. Slot 0 maps virtual page 0x00000 to physical page 0x00000. Slot 1 maps virtual page 0x02000 to physical page 0x00002. Slots 2 to 7 are loaded through a write port during configuration, and reset clears them. A lookup is a request strobe with an address. One clock later the block returns a response strobe, a hit flag and the physical address. A miss only lowers the hit flag. No fault handling, replacement, permission checks or table walks happen here.

Top module: `page_xlat_buf`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsp_vld`, `rsp_hit` and `rsp_pa` are zero. Reset invalidates slots 2 to 7, so mappings loaded before it miss afterwards. Slots 0 and 1 still hit.
- R2: A lookup of any address whose bits 31:12 equal 0x00000 hits, with physical page 0 (pa bits 14:12 = 0).
- R3: A lookup of any address whose bits 31:12 equal 0x02000 hits, with pa bits 14:12 = 2.
- R4: A write with `wr_en`=1 and `wr_idx` from 2 to 7 stores (`wr_vpn`, `wr_ppn`) in that slot and marks it valid. Later lookups of that page hit.
- R5: A write with `wr_idx` equal to 0 or 1 has no effect. The page it carries still misses, and the fixed mappings are unchanged.
- R6: On a hit, `rsp_pa` = {ppn[2:0], va[11:0]}, where ppn is the matched physical page number.
- R7: When several valid slots hold the same virtual page, the lowest-numbered slot supplies the physical page.
- R8: On a miss, `rsp_vld`=1, `rsp_hit`=0 and `rsp_pa`=0.
- R9: `rsp_vld` is high exactly one cycle after a cycle with `lk_req` high. When `rsp_vld` is low, `rsp_hit` and `rsp_pa` are zero.
- R10: A lookup in the same cycle as a write sees the table as it was before that write. The new mapping is visible from the next cycle on.
- R11: A second write to a slot replaces its earlier mapping. The old virtual page then misses unless another slot holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 3 | Slot number to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| lk_req | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| rsp_vld | output | 1 | Lookup response strobe, one cycle after request |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 15 | Translated physical address, zero on miss |

## Verification
The assertions assume that `lk_req` and `lk_va` are stable and known at each rising edge. They also assume reset is held for at least one edge before any request, so the first-cycle behaviour of the response register is well defined. The stimulus drives every input on the falling edge and keeps `lk_req` low throughout reset. It draws random virtual pages from a small pool that includes the two fixed pages, so repeated matches, the fixed mappings and misses all occur often, and it never leaves an input unknown.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = 20;
    localparam int PA_W     = 15;
    localparam int FRAME_W  = PA_W - OFF_W;
    localparam int N_ENT    = 8;
    localparam int N_FIXED  = 2;
    localparam int IDX_W    = $clog2(N_ENT);

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [PA_W-1:0]  pa_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        ppn_t ppn;
    } xlat_ent_t;

    typedef struct packed {
        logic vld;
        logic hit;
        pa_t  pa;
    } xlat_rsp_t;

    // Hard-wired mappings for the low slots
    function automatic xlat_ent_t fixed_entry(input int idx);
        xlat_ent_t e;
        e = '0;
        case (idx)
            0: begin e.valid = 1'b1; e.vpn = 20'h00000; e.ppn = 20'h00000; end
            1: begin e.valid = 1'b1; e.vpn = 20'h02000; e.ppn = 20'h00002; end
            default: e = '0;
        endcase
        return e;
    endfunction

    // Physical address from a frame number and an in-page offset
    function automatic pa_t make_pa(input ppn_t ppn, input logic [OFF_W-1:0] off);
        return {ppn[FRAME_W-1:0], off};
    endfunction

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
    import xlat_pkg::*;
#(
    parameter int NE = N_ENT,
    parameter int NF = N_FIXED,
    localparam int IW = $clog2(NE)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  vpn_t                  wr_vpn,
    input  ppn_t                  wr_ppn,
    output xlat_ent_t [NE-1:0]    ents_o
);

    for (genvar g = 0; g < NE; g++) begin : g_slot
        if (g < NF) begin : g_fixed
            assign ents_o[g] = fixed_entry(g);
        end else begin : g_prog
            xlat_ent_t ent_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q <= '0;
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    ent_q.valid <= 1'b1;
                    ent_q.vpn   <= wr_vpn;
                    ent_q.ppn   <= wr_ppn;
                end
            end
            assign ents_o[g] = ent_q;
        end
    end

endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int NE = N_ENT
) (
    input  xlat_ent_t [NE-1:0] ents_i,
    input  vpn_t               vpn_i,
    output logic [NE-1:0]      match_o
);

    for (genvar g = 0; g < NE; g++) begin : g_cmp
        assign match_o[g] = ents_i[g].valid && (ents_i[g].vpn == vpn_i);
    end

endmodule

// File: rtl/xlat_prio_sel.sv
module xlat_prio_sel
    import xlat_pkg::*;
#(
    parameter int NE = N_ENT
) (
    input  xlat_ent_t [NE-1:0] ents_i,
    input  logic [NE-1:0]      match_i,
    output logic               hit_o,
    output ppn_t               ppn_o
);

    // Scan from the top down so the lowest matching slot is assigned last
    always_comb begin
        hit_o = 1'b0;
        ppn_o = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o = 1'b1;
                ppn_o = ents_i[i].ppn;
            end
        end
    end

endmodule

// File: rtl/page_xlat_buf.sv
module page_xlat_buf
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa
);

    xlat_ent_t [N_ENT-1:0] ents;
    logic [N_ENT-1:0]      match;
    logic                  sel_hit;
    ppn_t                  sel_ppn;
    xlat_rsp_t             rsp_q;

    xlat_entry_store #(.NE(N_ENT), .NF(N_FIXED)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_vpn (wr_vpn),
        .wr_ppn (wr_ppn),
        .ents_o (ents)
    );

    xlat_match #(.NE(N_ENT)) u_match (
        .ents_i  (ents),
        .vpn_i   (lk_va[VA_W-1:OFF_W]),
        .match_o (match)
    );

    xlat_prio_sel #(.NE(N_ENT)) u_sel (
        .ents_i  (ents),
        .match_i (match),
        .hit_o   (sel_hit),
        .ppn_o   (sel_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.vld <= lk_req;
            rsp_q.hit <= lk_req && sel_hit;
            rsp_q.pa  <= (lk_req && sel_hit) ? make_pa(sel_ppn, lk_va[OFF_W-1:0]) : '0;
        end
    end

    assign rsp_vld = rsp_q.vld;
    assign rsp_hit = rsp_q.hit;
    assign rsp_pa  = rsp_q.pa;

endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk
    import xlat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_va,
    input logic             rsp_vld,
    input logic             rsp_hit,
    input logic [PA_W-1:0]  rsp_pa
);

    p_req_vld_r9: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_vld);

    p_idle_vld_r9: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_vld);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_vld |-> (!rsp_hit && rsp_pa == '0));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !rsp_hit) |-> rsp_pa == '0);

    p_offset_pass_r6: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (!rsp_hit || rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));

    p_fixed_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_va[VA_W-1:OFF_W] == 20'h00000)
        |=> (rsp_hit && rsp_pa == {3'd0, $past(lk_va[OFF_W-1:0])}));

    p_fixed_one_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_va[VA_W-1:OFF_W] == 20'h02000)
        |=> (rsp_hit && rsp_pa == {3'd2, $past(lk_va[OFF_W-1:0])}));

endmodule

bind page_xlat_buf xlat_buf_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .lk_req  (lk_req),
    .lk_va   (lk_va),
    .rsp_vld (rsp_vld),
    .rsp_hit (rsp_hit),
    .rsp_pa  (rsp_pa)
);

// File: tb/sim_page_xlat_buf.sv
`timescale 1ns/1ps
module sim_page_xlat_buf;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [19:0] wr_vpn;
    logic [19:0] wr_ppn;
    logic        lk_req;
    logic [31:0] lk_va;
    logic        rsp_vld;
    logic        rsp_hit;
    logic [14:0] rsp_pa;

    int n_chk  = 0;
    int n_fail = 0;

    // reference table
    bit          m_vld [8];
    logic [19:0] m_vpn [8];
    logic [19:0] m_ppn [8];

    logic [19:0] pool [8];

    always #4 clk = ~clk;

    page_xlat_buf u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_ppn(wr_ppn), .lk_req(lk_req), .lk_va(lk_va),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa)
    );

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin
            m_vld[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0;
        end
        m_vld[0] = 1'b1; m_vpn[0] = 20'h00000; m_ppn[0] = 20'h00000;
        m_vld[1] = 1'b1; m_vpn[1] = 20'h02000; m_ppn[1] = 20'h00002;
    endfunction

    function automatic void model_write(input logic [2:0] idx, input logic [19:0] v, input logic [19:0] p);
        if (idx >= 3'd2) begin
            m_vld[idx] = 1'b1; m_vpn[idx] = v; m_ppn[idx] = p;
        end
    endfunction

    function automatic void model_lookup(input logic [31:0] va, output bit hit, output logic [14:0] pa);
        hit = 1'b0; pa = '0;
        for (int i = 0; i < 8; i++) begin
            if (!hit && m_vld[i] && m_vpn[i] == va[31:12]) begin
                hit = 1'b1;
                pa  = {m_ppn[i][2:0], va[11:0]};
            end
        end
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock: drive at falling edge, check response at the next falling edge
    task automatic cycle(input bit dw, input logic [2:0] idx, input logic [19:0] v, input logic [19:0] p,
                         input bit dl, input logic [31:0] va, input string req);
        bit          eh;
        logic [14:0] ep;
        wr_en = dw; wr_idx = idx; wr_vpn = v; wr_ppn = p;
        lk_req = dl; lk_va = va;
        model_lookup(va, eh, ep);
        @(negedge clk);
        if (dw) model_write(idx, v, p);
        wr_en = 1'b0; lk_req = 1'b0;
        if (dl) begin
            check(req, "vld", {31'd0, rsp_vld}, 32'd1);
            check(req, "hit", {31'd0, rsp_hit}, {31'd0, eh});
            check(req, "pa",  {17'd0, rsp_pa},  {17'd0, ep});
        end else begin
            check(req, "vld idle", {31'd0, rsp_vld}, 32'd0);
            check(req, "pa idle",  {17'd0, rsp_pa},  32'd0);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [19:0] v, input logic [19:0] p, input string req);
        cycle(1'b1, idx, v, p, 1'b0, 32'd0, req);
    endtask

    task automatic lk(input logic [31:0] va, input string req);
        cycle(1'b0, 3'd0, 20'd0, 20'd0, 1'b1, va, req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "vld in reset", {31'd0, rsp_vld}, 32'd0);
        check("R1", "hit in reset", {31'd0, rsp_hit}, 32'd0);
        check("R1", "pa in reset",  {17'd0, rsp_pa},  32'd0);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check("R1", "vld after reset", {31'd0, rsp_vld}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_ppn = '0;
        lk_req = 1'b0; lk_va = '0;
        model_reset();
        @(negedge clk);
        do_reset();

        // fixed slots
        lk(32'h0000_0ABC, "R2");
        lk(32'h0000_0FFF, "R2");
        lk(32'h0200_0123, "R3");
        lk(32'h0200_0000, "R3");
        lk(32'h1234_5678, "R8");
        cycle(1'b0, 3'd0, 20'd0, 20'd0, 1'b0, 32'd0, "R9");

        // programmable slots
        wr(3'd2, 20'h12345, 20'h00007, "R4");
        lk(32'h1234_5678, "R4");
        lk(32'h1234_5FFF, "R6");
        wr(3'd7, 20'hFFFFF, 20'hABCD5, "R4");
        lk(32'hFFFF_F001, "R6");

        // writes to fixed slots ignored
        wr(3'd0, 20'h55555, 20'h00003, "R5");
        wr(3'd1, 20'h02000, 20'h00006, "R5");
        lk(32'h5555_5010, "R5");
        lk(32'h0200_0444, "R5");
        lk(32'h0000_0444, "R5");

        // lowest index wins
        wr(3'd5, 20'h0AAAA, 20'h00001, "R7");
        wr(3'd3, 20'h0AAAA, 20'h00004, "R7");
        lk(32'h0AAA_A321, "R7");
        wr(3'd4, 20'h02000, 20'h00005, "R7");
        lk(32'h0200_0321, "R7");

        // same-cycle write and lookup
        cycle(1'b1, 3'd6, 20'h0BEEF, 20'h00003, 1'b1, 32'h0BEE_F111, "R10");
        lk(32'h0BEE_F111, "R10");

        // overwrite
        wr(3'd6, 20'h0CAFE, 20'h00002, "R11");
        lk(32'h0BEE_F111, "R11");
        lk(32'h0CAF_E222, "R11");

        // reset drops programmed slots
        do_reset();
        lk(32'h1234_5678, "R1");
        lk(32'h0CAF_E222, "R1");
        lk(32'h0000_0010, "R1");

        // random mix
        pool[0] = 20'h00000; pool[1] = 20'h02000;
        for (int i = 2; i < 8; i++) pool[i] = 20'($urandom);
        for (int n = 0; n < 400; n++) begin
            bit          dw = ($urandom % 3) == 0;
            bit          dl = ($urandom % 4) != 0;
            logic [2:0]  idx = 3'($urandom);
            logic [19:0] v   = pool[$urandom % 8];
            logic [19:0] p   = 20'($urandom);
            logic [31:0] va  = {pool[$urandom % 8], 12'($urandom)};
            cycle(dw, idx, v, p, dl, va, "R4 R6 R7 R8 R10");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule